// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current in one H-bridge. Two direction bits choose which side of each leg drives the load. An external comparator reports when the sensed current has passed its reference. The block then removes the conducting low-side switch for a fixed number of clock cycles, called the off time. During that time the load current circulates through both high-side switches. When the off time expires, the bridge goes back to the pattern set by the direction bits. Each leg has its own dead-time counter. No gate can turn on until both switches of its leg have been off for the programmed number of cycles. After each low-side turn-on, the comparator is masked for a programmable window so that the recovery spike cannot start a new off period.

One instance is used per bridge. The comparator and the gate drivers sit outside the block. The off time, dead time and blanking window are parameters given in clock cycles.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: The high-side and low-side gate of the same leg are never asserted in the same cycle.
- R2: While `en_i` is low, every gate and `off_phase_o` are deasserted from the next cycle on, and any running off period is abandoned.
- R3: A gate of a leg turns on only after both gates of that leg have been off for at least DEAD_CYC consecutive cycles. This also applies after reset and after re-enable.
- R4: Outside the off period, leg k drives its high side when `dir_i[k]` is 1 and its low side when `dir_i[k]` is 0.
- R5: The comparator flag starts an off period when all of these hold in one cycle: `over_i` is high, the block is in the on phase, `dir_i[0]` differs from `dir_i[1]`, a low-side gate is on, and the blanking window is not active. In the next cycle the low-side gate drops and `off_phase_o` rises. `off_phase_o` then stays high for exactly TOFF_CYC cycles.
- R6: During the off period both low-side gates are off. The leg that was driving low turns its high side on after the dead time, so that both high sides conduct.
- R7: After an off period starts, the low side stays off for TOFF_CYC + DEAD_CYC cycles in total.
- R8: The comparator flag is ignored for BLANK_CYC cycles. The window starts with the first cycle in which a low-side gate reads high.
- R9: A high comparator flag during the off period neither extends nor restarts it.
- R10: When both direction bits are equal, no off period starts, whatever `over_i` does.
- R11: A change of the direction bits during the off period has no effect until the period ends. The new pattern is then applied through the dead time.
- R12: After synchronous reset, all gates and `off_phase_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Bridge enable; low switches every gate off |
| dir_i | input | 2 | Side selection per leg: bit k = 1 selects the high side of leg k, 0 selects the low side |
| over_i | input | 1 | Comparator flag: sensed current above the reference |
| gate_hs_o | output | 2 | High-side gate enables, bit k for leg k |
| gate_ls_o | output | 2 | Low-side gate enables, bit k for leg k |
| off_phase_o | output | 1 | High while the fixed off period runs |

## Verification
Any fault inside this block shows up at the gate outputs within a few cycles:

- A leg counter that releases a gate too early shows up at the next transition of that leg. The gate turns on after fewer than DEAD_CYC dark cycles.
- A one-shot counter that loads or counts wrongly changes how long `off_phase_o` stays high. The error is visible when the low side comes back, TOFF_CYC + DEAD_CYC cycles after the trigger.
- A blanking counter that is off by one lets a held comparator flag trigger one cycle too early or too late. That cycle can be observed directly on `gate_ls_o`.
- A phase register that ignores the direction bits or the enable gives a wrong gate pattern by the second cycle after the input changes.

// File: rtl/chop_pkg.sv
// Shared types for the constant off-time chopper.
// Assumes a bridge made of exactly two legs.
package chop_pkg;

    localparam int NUM_LEGS = 2;

    // Drive state requested for, or applied to, one leg.
    typedef enum logic [1:0] {
        LEG_OFF = 2'b00,
        LEG_HI  = 2'b01,
        LEG_LO  = 2'b10
    } leg_drive_e;

    // Chopping phase of the bridge.
    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } chop_phase_e;

endpackage

// File: rtl/chop_leg_gate.sv
// One bridge leg with dead-time insertion.
// Follows the requested drive state. Any change first turns both gates off.
// A gate turns on only after DEAD_CYC consecutive cycles with both gates off.
// Assumes DEAD_CYC >= 1. The counter starts from zero at reset.
module chop_leg_gate
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  leg_drive_e req_i,
    output logic       hs_o,
    output logic       ls_o
);

    localparam int DCNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [DCNT_W-1:0] DEAD_LAST = DCNT_W'(DEAD_CYC - 1);

    leg_drive_e        drv_q;
    logic [DCNT_W-1:0] dark_q;

    // Applied drive state and count of cycles with both gates off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q  <= LEG_OFF;
            dark_q <= '0;
        end else if (drv_q != LEG_OFF) begin
            if (req_i != drv_q) begin
                drv_q  <= LEG_OFF;
                dark_q <= '0;
            end
        end else begin
            if (dark_q != DEAD_LAST) begin
                dark_q <= dark_q + 1'b1;
            end
            if (dark_q == DEAD_LAST && req_i != LEG_OFF) begin
                drv_q <= req_i;
            end
        end
    end

    // Decode the gate enables straight from the state flop.
    assign hs_o = (drv_q == LEG_HI);
    assign ls_o = (drv_q == LEG_LO);

endmodule

// File: rtl/chop_blank_win.sv
// Comparator blanking window.
// Active in the cycle a low-side gate is first seen high and for BLANK_CYC-1 cycles after.
// Assumes BLANK_CYC >= 1.
module chop_blank_win
    import chop_pkg::*;
#(
    parameter int BLANK_CYC = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LEGS-1:0] ls_on_i,
    output logic                blank_o
);

    localparam int BCNT_W = $clog2(BLANK_CYC + 1);
    localparam logic [BCNT_W-1:0] BLANK_LAST = BCNT_W'(BLANK_CYC - 1);

    logic [NUM_LEGS-1:0] ls_prev_q;
    logic [BCNT_W-1:0]   left_q;
    logic                ls_rise;

    assign ls_rise = |(ls_on_i & ~ls_prev_q);
    assign blank_o = ls_rise || (left_q != '0);

    // Remember the low-side gates to find their rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_prev_q <= '0;
        end else begin
            ls_prev_q <= ls_on_i;
        end
    end

    // Count the remaining masked cycles after a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (ls_rise) begin
            left_q <= BLANK_LAST;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/chop_offtime_seq.sv
// Phase sequencer and one-shot timer.
// Decides the per-leg drive request from the enable, the direction bits and the phase.
// The off period is started combinationally, so the legs react at the next edge.
// It lasts TOFF_CYC cycles and cannot be restarted while running.
// Assumes TOFF_CYC > DEAD_CYC so that slow decay actually engages.
module chop_offtime_seq
    import chop_pkg::*;
#(
    parameter int TOFF_CYC = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [NUM_LEGS-1:0] dir_i,
    input  logic                over_i,
    input  logic [NUM_LEGS-1:0] ls_on_i,
    input  logic                blank_i,
    output leg_drive_e          req_o [NUM_LEGS],
    output logic                off_phase_o
);

    localparam int TCNT_W = $clog2(TOFF_CYC + 1);
    localparam logic [TCNT_W-1:0] TOFF_LAST = TCNT_W'(TOFF_CYC - 1);

    chop_phase_e       phase_q;
    logic [TCNT_W-1:0] tleft_q;
    logic              split_drive;
    logic              fire;
    logic              expire;
    logic              hold_decay;

    assign split_drive = dir_i[0] ^ dir_i[1];
    assign fire        = en_i && (phase_q == PH_ON) && split_drive &&
                         (|ls_on_i) && !blank_i && over_i;
    assign expire      = (phase_q == PH_OFF) && (tleft_q == '0);
    assign hold_decay  = fire || ((phase_q == PH_OFF) && !expire);
    assign off_phase_o = (phase_q == PH_OFF);

    // Per-leg request: off, slow decay on both high sides, or the direction pattern.
    always_comb begin
        for (int k = 0; k < NUM_LEGS; k++) begin
            if (!en_i) begin
                req_o[k] = LEG_OFF;
            end else if (hold_decay) begin
                req_o[k] = LEG_HI;
            end else begin
                req_o[k] = dir_i[k] ? LEG_HI : LEG_LO;
            end
        end
    end

    // Phase register and one-shot countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ON;
            tleft_q <= '0;
        end else if (!en_i) begin
            phase_q <= PH_ON;
            tleft_q <= '0;
        end else if (fire) begin
            phase_q <= PH_OFF;
            tleft_q <= TOFF_LAST;
        end else if (phase_q == PH_OFF) begin
            if (expire) begin
                phase_q <= PH_ON;
            end else begin
                tleft_q <= tleft_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/chop_bridge_ctrl.sv
// Top of the constant off-time chopper for one H-bridge.
// Connects the phase sequencer, the blanking window and one dead-time leg per side.
// Assumes the comparator flag is already synchronous to clk.
module chop_bridge_ctrl #(
    parameter int TOFF_CYC  = 20,
    parameter int DEAD_CYC  = 4,
    parameter int BLANK_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] dir_i,
    input  logic       over_i,
    output logic [1:0] gate_hs_o,
    output logic [1:0] gate_ls_o,
    output logic       off_phase_o
);
    import chop_pkg::*;

    leg_drive_e leg_req [NUM_LEGS];
    logic       blank;

    chop_offtime_seq #(
        .TOFF_CYC (TOFF_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .dir_i       (dir_i),
        .over_i      (over_i),
        .ls_on_i     (gate_ls_o),
        .blank_i     (blank),
        .req_o       (leg_req),
        .off_phase_o (off_phase_o)
    );

    chop_blank_win #(
        .BLANK_CYC (BLANK_CYC)
    ) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ls_on_i (gate_ls_o),
        .blank_o (blank)
    );

    // One dead-time leg per bridge side.
    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
        chop_leg_gate #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (leg_req[k]),
            .hs_o  (gate_hs_o[k]),
            .ls_o  (gate_ls_o[k])
        );
    end

endmodule

// File: rtl/chop_bridge_checker.sv
// Port-level properties of the chopper. Attached to every instance by the bind below.
// Window lengths are measured with counters, not deep $past.
module chop_bridge_checker #(
    parameter int TOFF_CYC = 20,
    parameter int DEAD_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic [1:0] dir_i,
    input logic [1:0] gate_hs_o,
    input logic [1:0] gate_ls_o,
    input logic       off_phase_o
);

    localparam int GAP_W = $clog2(DEAD_CYC + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DEAD_CYC);
    localparam int RUN_W = $clog2(TOFF_CYC + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TOFF_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_EXP = RUN_W'(TOFF_CYC);

    logic [RUN_W-1:0] off_run_q;

    // Length of the current off period, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (!off_phase_o) begin
            off_run_q <= '0;
        end else if (off_run_q != RUN_MAX) begin
            off_run_q <= off_run_q + 1'b1;
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_leg
        logic [GAP_W-1:0] gap_q;

        // Consecutive cycles with both gates of this leg off.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q <= '0;
            end else if (gate_hs_o[k] || gate_ls_o[k]) begin
                gap_q <= '0;
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
        end

        a_r1_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hs_o[k] && gate_ls_o[k]));

        a_r3_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hs_o[k]) || $rose(gate_ls_o[k])) |-> (gap_q >= GAP_MAX));
    end

    a_r2_disable_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (gate_hs_o == 2'b00 && gate_ls_o == 2'b00 && !off_phase_o));

    a_r5_off_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(off_phase_o) && $past(en_i)) |-> (off_run_q == RUN_EXP));

    a_r6_decay_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        off_phase_o |-> (gate_ls_o == 2'b00));

    a_r10_equal_no_chop: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i[0] == dir_i[1] && !off_phase_o) |=> !off_phase_o);

endmodule

bind chop_bridge_ctrl chop_bridge_checker #(
    .TOFF_CYC (TOFF_CYC),
    .DEAD_CYC (DEAD_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .dir_i       (dir_i),
    .gate_hs_o   (gate_hs_o),
    .gate_ls_o   (gate_ls_o),
    .off_phase_o (off_phase_o)
);

// File: tb/chop_bridge_ctrl_bench.sv
// Bench for the chopper with defaults TOFF_CYC=20, DEAD_CYC=4, BLANK_CYC=6.
// Each table row drives the inputs at a falling edge, waits the given number
// of rising edges, and checks the outputs at the next falling edge.
module chop_bridge_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [1:0] dir_i = 2'b00;
    logic       over_i = 1'b0;
    logic [1:0] gate_hs_o;
    logic [1:0] gate_ls_o;
    logic       off_phase_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chop_bridge_ctrl u_chop_bridge_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .dir_i       (dir_i),
        .over_i      (over_i),
        .gate_hs_o   (gate_hs_o),
        .gate_ls_o   (gate_ls_o),
        .off_phase_o (off_phase_o)
    );

    // Row fields: en, dir[1:0], over, edges[7:0], hs[1:0], ls[1:0], off, requirement[7:0]
    localparam logic [24:0] STEPS [NSTEP] = '{
        {1'b1, 2'b01, 1'b0, 8'd3,  2'b00, 2'b00, 1'b0, 8'd3},  // R3 dark after reset
        {1'b1, 2'b01, 1'b0, 8'd1,  2'b01, 2'b10, 1'b0, 8'd4},  // R4 pattern appears
        {1'b1, 2'b01, 1'b1, 8'd5,  2'b01, 2'b10, 1'b0, 8'd8},  // R8 flag blanked
        {1'b1, 2'b01, 1'b0, 8'd2,  2'b01, 2'b10, 1'b0, 8'd8},  // R8 window runs out
        {1'b1, 2'b01, 1'b1, 8'd1,  2'b01, 2'b00, 1'b1, 8'd5},  // R5 trigger
        {1'b1, 2'b01, 1'b0, 8'd3,  2'b01, 2'b00, 1'b1, 8'd3},  // R3 dead before decay
        {1'b1, 2'b01, 1'b0, 8'd1,  2'b11, 2'b00, 1'b1, 8'd6},  // R6 both high sides
        {1'b1, 2'b01, 1'b1, 8'd15, 2'b11, 2'b00, 1'b1, 8'd9},  // R9 flag in off period
        {1'b1, 2'b01, 1'b0, 8'd1,  2'b01, 2'b00, 1'b0, 8'd5},  // R5 ends after TOFF
        {1'b1, 2'b01, 1'b0, 8'd3,  2'b01, 2'b00, 1'b0, 8'd7},  // R7 still dark
        {1'b1, 2'b01, 1'b0, 8'd1,  2'b01, 2'b10, 1'b0, 8'd7},  // R7 low side back at TOFF+DEAD
        {1'b1, 2'b01, 1'b1, 8'd6,  2'b01, 2'b10, 1'b0, 8'd8},  // R8 held flag blanked
        {1'b1, 2'b01, 1'b1, 8'd1,  2'b01, 2'b00, 1'b1, 8'd5},  // R5 trigger after window
        {1'b1, 2'b10, 1'b0, 8'd10, 2'b11, 2'b00, 1'b1, 8'd11}, // R11 change held off
        {1'b1, 2'b10, 1'b0, 8'd10, 2'b10, 2'b00, 1'b0, 8'd11}, // R11 new pattern, dead first
        {1'b1, 2'b10, 1'b0, 8'd4,  2'b10, 2'b01, 1'b0, 8'd4},  // R4 reversed pattern
        {1'b1, 2'b11, 1'b1, 8'd1,  2'b10, 2'b00, 1'b0, 8'd10}, // R10 equal dirs, no chop
        {1'b1, 2'b11, 1'b1, 8'd4,  2'b11, 2'b00, 1'b0, 8'd10}, // R10 both high
        {1'b1, 2'b00, 1'b1, 8'd10, 2'b00, 2'b11, 1'b0, 8'd10}, // R10 both low, flag ignored
        {1'b0, 2'b01, 1'b1, 8'd1,  2'b00, 2'b00, 1'b0, 8'd2},  // R2 disable
        {1'b0, 2'b01, 1'b1, 8'd5,  2'b00, 2'b00, 1'b0, 8'd2},  // R2 stays dark
        {1'b1, 2'b01, 1'b0, 8'd1,  2'b01, 2'b10, 1'b0, 8'd3}   // R3 dark time already served
    };

    // Compare the outputs with the expected values and count the result.
    task automatic check(input int req, input int idx, input logic [1:0] ehs,
                         input logic [1:0] els, input logic eoff);
        n_checks++;
        if (gate_hs_o !== ehs || gate_ls_o !== els || off_phase_o !== eoff) begin
            n_errors++;
            $display("FAIL R%0d step %0d: hs=%b ls=%b off=%b expected hs=%b ls=%b off=%b",
                     req, idx, gate_hs_o, gate_ls_o, off_phase_o, ehs, els, eoff);
        end
    endtask

    // Drive at the current falling edge, wait n rising edges, land on a falling edge.
    task automatic run(input logic en, input logic [1:0] dir, input logic ov, input int n);
        en_i   = en;
        dir_i  = dir;
        over_i = ov;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(12, -1, 2'b00, 2'b00, 1'b0);  // R12 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) begin
            run(STEPS[i][24], STEPS[i][23:22], STEPS[i][21], int'(STEPS[i][20:13]));
            check(int'(STEPS[i][7:0]), i, STEPS[i][12:11], STEPS[i][10:9], STEPS[i][8]);
        end

        // R8 window after re-enable, then R5 trigger, then R2 abort of the off period
        run(1'b1, 2'b01, 1'b0, 6);
        check(8, 100, 2'b01, 2'b10, 1'b0);
        run(1'b1, 2'b01, 1'b1, 1);
        check(5, 101, 2'b01, 2'b00, 1'b1);
        run(1'b0, 2'b01, 1'b0, 1);
        check(2, 102, 2'b00, 2'b00, 1'b0);
        // R3: after the abort both legs stay dark for the dead time
        run(1'b1, 2'b01, 1'b0, 2);
        check(3, 103, 2'b00, 2'b00, 1'b0);
        run(1'b1, 2'b01, 1'b0, 2);
        check(4, 104, 2'b01, 2'b10, 1'b0);
        // R12: synchronous reset clears the gates on the next edge
        rst_n = 1'b0;
        run(1'b1, 2'b01, 1'b0, 1);
        check(12, 105, 2'b00, 2'b00, 1'b0);
        rst_n = 1'b1;
        run(1'b1, 2'b01, 1'b0, 2);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule